// File: doc/BRIEF.md
# Keyed Write Gate for a Watchdog Register Window

This block sits between a simple single-cycle register bus and a watchdog timer core. It decodes a 16-byte register window. Writes that could change the watchdog's behaviour are refused unless the bus first writes two key values to the reload offset, in order. The guarded writes are the two timeout preloads and the keepalive / flag-clear word. A single unlock allows exactly one wide write, whether or not that write hits a guarded register. Byte writes can only move the key sequence forward.

The block turns each permitted write into a one-cycle strobe for the timer core. The strobes are a load of preload 1 or preload 2 with a 20-bit value, a keepalive, and a clear of the previous-timeout flag. The timer core owns that flag and presents it to the block. The block returns it on reads of the reload offset. The strobes and the read data are combinational and appear in the same cycle as the bus access. Only the unlock state is registered.

Top module: `keyed_reg_gate`

## Requirements
- R1: After reset, and after any reset that lands in the middle of an unlock, the gate is locked. No strobe fires, and a wide write to a guarded register has no effect.
- R2: Size codes are 0 for byte, 1 for 16-bit and 2 for 32-bit. A write to offset 0xC whose value, zero-extended from its size, equals 0x80 arms the gate from any state. Examples are a byte write of 0x80 or a 16-bit write of 0x0080.
- R3: A write of 0x86 to offset 0xC while armed opens the gate. This works for any size.
- R4: A write of 0x86 to offset 0xC while locked is ignored, and the gate stays locked.
- R5: While open, any 16-bit or 32-bit write that is not an arming write relocks the gate, whatever its offset. At most one guarded action follows each opening.
- R6: Byte writes never produce a strobe. A byte write that is not a key write leaves the state as it was, including the open state.
- R7: An open 32-bit write at offset 0x0 pulses the preload-1 load, and one at offset 0x4 pulses the preload-2 load. In both cases the preload data carries the write's bits 19:0.
- R8: An open 16-bit write at offset 0xC with bit 8 set pulses the keepalive.
- R9: An open 16-bit write at offset 0xC with bit 9 or bit 12 set pulses the flag clear.
- R10: A 16-bit read of offset 0xC returns the previous-timeout flag on both bit 9 and bit 12. Every other read returns zero, and reads never change the state.
- R11: Strobes last one cycle, come in the same cycle as the write, and never appear while the gate is locked or armed.
- R12: While open, a 16-bit or 32-bit write of 0x86 to offset 0xC counts as an ordinary data write. It relocks the gate and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_vld | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 unused (ignored) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| tmo_flag | input | 1 | Previous-timeout flag held by the timer core |
| ld_pre1 | output | 1 | Load strobe for preload 1 |
| ld_pre2 | output | 1 | Load strobe for preload 2 |
| pre_data | output | 20 | Preload value accompanying a load strobe |
| keepalive | output | 1 | Keepalive strobe |
| flag_clr | output | 1 | Previous-timeout flag clear strobe |

## Verification
The open state is the hard case to reach and to observe. Nothing shows it at the ports, and it disappears after one wide write. The bench therefore steers the gate into each of its three states with fixed key sequences before every operation. It then applies the operation, drawn from a sweep over offsets, sizes and data patterns, including 0xFF80, which is a key only as a byte. After the operation it reads out the resulting state with a probe: a guarded load, then a second key and another load. All results are compared against a state model kept in the bench.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} sz_e;
  typedef enum logic [1:0] {ST_LOCK = 2'd0, ST_ARMED = 2'd1, ST_OPEN = 2'd2} ust_e;
  typedef struct packed {
    logic key_a;    // arming key write
    logic key_b;    // opening key write
    logic byte_wr;  // byte-size write
    logic data_wr;  // wide write that is not an arming key
  } wcls_t;
endpackage

// File: rtl/kg_classify.sv
module kg_classify
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_OFF = 4'hC,
  parameter logic [7:0] KEY_A = 8'h80,
  parameter logic [7:0] KEY_B = 8'h86
) (
  input  logic              vld,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  sz_e               size,
  input  logic [DATA_W-1:0] wdata,
  output wcls_t             cls
);
  localparam int unsigned HALF_W = 16;

  logic [DATA_W-1:0] val;
  logic              wr_ok;
  logic              at_key;

  always_comb begin
    case (size)
      SZ_B:    val = {{(DATA_W-8){1'b0}}, wdata[7:0]};
      SZ_H:    val = {{(DATA_W-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
      default: val = wdata;
    endcase
  end

  assign wr_ok  = vld & wr & (size != SZ_X);
  assign at_key = (addr == KEY_OFF);

  always_comb begin
    cls.key_a   = wr_ok & at_key & (val == DATA_W'(KEY_A));
    cls.key_b   = wr_ok & at_key & (val == DATA_W'(KEY_B));
    cls.byte_wr = wr_ok & (size == SZ_B);
    cls.data_wr = wr_ok & (size != SZ_B) & ~cls.key_a;
  end
endmodule

// File: rtl/kg_unlock_fsm.sv
module kg_unlock_fsm
  import kg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wcls_t cls,
  output logic  open
);
  ust_e st_q, st_d;
  logic st_en;

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (cls.key_a) begin
      st_d  = ST_ARMED;
      st_en = 1'b1;
    end else if (cls.key_b && st_q == ST_ARMED) begin
      st_d  = ST_OPEN;
      st_en = 1'b1;
    end else if (cls.data_wr && st_q == ST_OPEN) begin
      st_d  = ST_LOCK;
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_LOCK;
    else if (st_en) st_q <= st_d;
  end

  assign open = (st_q == ST_OPEN);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && cls.key_b) |=> (st_q == ST_LOCK));
  // R3
  arm_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && cls.key_b) |=> (st_q == ST_OPEN));
  // R5
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && cls.data_wr) |=> (st_q == ST_LOCK));
  // R6
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && cls.byte_wr && !cls.key_a) |=> (st_q == ST_OPEN));
endmodule

// File: rtl/kg_action.sv
module kg_action
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PRE_W  = 20,
  parameter logic [ADDR_W-1:0] PRE1_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] PRE2_OFF = 4'h4,
  parameter logic [ADDR_W-1:0] KEY_OFF  = 4'hC,
  parameter int unsigned KA_BIT  = 8,
  parameter int unsigned CLR_A   = 9,
  parameter int unsigned CLR_B   = 12
) (
  input  logic              open,
  input  wcls_t             cls,
  input  logic [ADDR_W-1:0] addr,
  input  sz_e               size,
  input  logic [PRE_W-1:0]  wd,
  output logic              ld_pre1,
  output logic              ld_pre2,
  output logic [PRE_W-1:0]  pre_data,
  output logic              keepalive,
  output logic              flag_clr
);
  logic grant;
  logic half_key;

  assign grant     = open & cls.data_wr;
  assign half_key  = grant & (size == SZ_H) & (addr == KEY_OFF);
  assign ld_pre1   = grant & (size == SZ_W) & (addr == PRE1_OFF);
  assign ld_pre2   = grant & (size == SZ_W) & (addr == PRE2_OFF);
  assign keepalive = half_key & wd[KA_BIT];
  assign flag_clr  = half_key & (wd[CLR_A] | wd[CLR_B]);
  assign pre_data  = wd;
endmodule

// File: rtl/kg_rdmux.sv
module kg_rdmux
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_OFF = 4'hC,
  parameter int unsigned FLAG_A = 9,
  parameter int unsigned FLAG_B = 12
) (
  input  logic              vld,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  sz_e               size,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic hit;

  assign hit = vld & ~wr & (size == SZ_H) & (addr == KEY_OFF);

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[FLAG_A] = flag;
      rdata[FLAG_B] = flag;
    end
  end
endmodule

// File: rtl/keyed_reg_gate.sv
module keyed_reg_gate
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmo_flag,
  output logic              ld_pre1,
  output logic              ld_pre2,
  output logic [PRE_W-1:0]  pre_data,
  output logic              keepalive,
  output logic              flag_clr
);
  localparam logic [ADDR_W-1:0] OFF_PRE1 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_PRE2 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_KEY  = ADDR_W'(12);

  logic [SYNC_STAGES-1:0] rst_sh;
  logic                   rst_q;
  sz_e                    size;
  wcls_t                  cls;
  logic                   open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_sh[SYNC_STAGES-1];

  assign size = sz_e'(bus_size);

  kg_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_OFF(OFF_KEY)) u_cls (
    .vld(bus_vld), .wr(bus_wr), .addr(bus_addr), .size(size),
    .wdata(bus_wdata), .cls(cls)
  );

  kg_unlock_fsm u_fsm (
    .clk(clk), .rst_n(rst_q), .cls(cls), .open(open)
  );

  kg_action #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .PRE1_OFF(OFF_PRE1),
              .PRE2_OFF(OFF_PRE2), .KEY_OFF(OFF_KEY)) u_act (
    .open(open), .cls(cls), .addr(bus_addr), .size(size),
    .wd(bus_wdata[PRE_W-1:0]), .ld_pre1(ld_pre1), .ld_pre2(ld_pre2),
    .pre_data(pre_data), .keepalive(keepalive), .flag_clr(flag_clr)
  );

  kg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_OFF(OFF_KEY)) u_rd (
    .vld(bus_vld), .wr(bus_wr), .addr(bus_addr), .size(size),
    .flag(tmo_flag), .rdata(bus_rdata)
  );

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ld_pre1 | ld_pre2 | keepalive | flag_clr) |=>
    !(ld_pre1 | ld_pre2 | keepalive | flag_clr));
  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ld_pre1, ld_pre2, keepalive | flag_clr}));
  // R6
  byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_vld && size == SZ_B) |-> !(ld_pre1 | ld_pre2 | keepalive | flag_clr));
  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!bus_vld || bus_wr) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_keyed_reg_gate.sv
module sim_keyed_reg_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        tmo_flag = 1'b0;
  logic        ld_pre1, ld_pre2, keepalive, flag_clr;
  logic [19:0] pre_data;

  int total = 0;
  int bad = 0;
  int mst = 0;  // model state: 0 locked, 1 armed, 2 open

  always #5 clk = ~clk;

  keyed_reg_gate u0 (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmo_flag(tmo_flag), .ld_pre1(ld_pre1),
    .ld_pre2(ld_pre2), .pre_data(pre_data), .keepalive(keepalive),
    .flag_clr(flag_clr)
  );

  function automatic logic [31:0] sized(input logic [1:0] s, input logic [31:0] d);
    if (s == 2'd0) return {24'h0, d[7:0]};
    if (s == 2'd1) return {16'h0, d[15:0]};
    return d;
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic [1:0] s,
                                   input logic [31:0] d, input int st);
    bit ka = (a == 4'hC) && (sized(s, d) == 32'h80);
    bit kb = (a == 4'hC) && (sized(s, d) == 32'h86);
    if (ka) return "R2";
    if (s == 2'd0) return (kb && st == 1) ? "R3" : "R6";
    if (kb && st == 1) return "R3";
    if (kb && st == 0) return "R4";
    if (kb && st == 2) return "R12";
    if (st != 2) return "R11";
    if (s == 2'd2 && (a == 4'h0 || a == 4'h4)) return "R7";
    if (s == 2'd1 && a == 4'hC && d[8]) return "R8";
    if (s == 2'd1 && a == 4'hC && (d[9] || d[12])) return "R9";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    bit ka, kb, wide;
    logic [3:0]  e_stb;
    logic [31:0] act;
    string tg;
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    #1;
    ka   = (a == 4'hC) && (sized(s, d) == 32'h80);
    kb   = (a == 4'hC) && (sized(s, d) == 32'h86);
    wide = (s != 2'd0);
    e_stb[3] = (mst == 2) && wide && !ka && s == 2'd2 && a == 4'h0;
    e_stb[2] = (mst == 2) && wide && !ka && s == 2'd2 && a == 4'h4;
    e_stb[1] = (mst == 2) && !ka && s == 2'd1 && a == 4'hC && d[8];
    e_stb[0] = (mst == 2) && !ka && s == 2'd1 && a == 4'hC && (d[9] || d[12]);
    tg = tag_of(a, s, d, mst);
    act = {28'h0, ld_pre1, ld_pre2, keepalive, flag_clr};
    check(tg, act, {28'h0, e_stb});
    if (e_stb[3] || e_stb[2])
      check("R7", {12'h0, pre_data}, {12'h0, d[19:0]});
    if (ka) mst = 1;
    else if (kb && mst == 1) mst = 2;
    else if (mst == 2 && wide) mst = 0;
    @(posedge clk); #1;
    bus_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s);
    logic [31:0] e;
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = s; bus_wdata = 32'hFFFF_FFFF;
    #1;
    e = (a == 4'hC && s == 2'd1) ? ({31'h0, tmo_flag} << 9) | ({31'h0, tmo_flag} << 12) : 32'h0;
    check("R10", bus_rdata, e);
    check("R10", {28'h0, ld_pre1, ld_pre2, keepalive, flag_clr}, 32'h0);
    @(posedge clk); #1;
    bus_vld = 1'b0;
  endtask

  task automatic to_state(input int k);
    wr(4'hC, 2'd0, 32'h80);
    wr(4'hC, 2'd0, 32'h86);
    wr(4'h8, 2'd1, 32'h0);
    if (k >= 1) wr(4'hC, 2'd0, 32'h80);
    if (k == 2) wr(4'hC, 2'd1, 32'h86);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {28'h0, ld_pre1, ld_pre2, keepalive, flag_clr}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0]  addrs [4];
    logic [31:0] pats  [8];
    addrs = '{4'h0, 4'h4, 4'h8, 4'hC};
    pats  = '{32'h80, 32'h86, 32'hFF80, 32'h100, 32'h200, 32'h1000, 32'hABCDE123, 32'h0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle outputs after reset, and a guarded write without key is refused
    check("R1", bus_rdata, 32'h0);
    wr(4'h0, 2'd2, 32'h12345);
    // R1: reset while open relocks
    to_state(2);
    do_reset();
    begin
      bit pre = ld_pre1;
      check("R1", {31'h0, pre}, 32'h0);
    end
    wr(4'h0, 2'd2, 32'h54321);

    for (int st = 0; st < 3; st++)
      for (int ai = 0; ai < 4; ai++)
        for (int s = 0; s < 3; s++)
          for (int di = 0; di < 8; di++) begin
            to_state(st);
            wr(addrs[ai], s[1:0], pats[di]);
            // probe the state left behind
            wr(4'h0, 2'd2, 32'h5A5A5);
            wr(4'hC, 2'd1, 32'h86);
            wr(4'h4, 2'd2, 32'h13579);
          end

    // R10: read sweep with the gate open; reads must not consume it
    for (int f = 0; f < 2; f++) begin
      tmo_flag = f[0];
      to_state(2);
      for (int a = 0; a < 16; a++)
        for (int s = 0; s < 3; s++)
          rd(a[3:0], s[1:0]);
      wr(4'h0, 2'd2, 32'hFEDCB);
    end

    // R8 R9: combined keepalive and clear in one write
    to_state(2);
    wr(4'hC, 2'd1, 32'h1300);
    wr(4'hC, 2'd1, 32'h1300);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule